// File: doc/BRIEF.md
# Group-Selected Two-Port Handshaking Parallel Interface

This block gives a small processor two 8-bit parallel ports on its I/O bus. Access hangs behind a group latch. The processor first writes a group number to address 1. Only while that latched number equals the block's own group number do the other addresses reach anything:

- a direction register
- a status register
- the two port data registers

When the group does not match, reads return zero and register writes are dropped.

Each port has a ready/strobe handshake with its peripheral, and the rule depends on the port's direction.

- **Output port:** a processor write to its data register raises ready. The peripheral's strobe drops ready.
- **Input port:** a processor read of its data register raises ready. The peripheral's strobe drops ready and captures the incoming byte. After reset an input port shows no ready until one dummy read has been made.

The strobe is brought into the clock domain through a synchronizer, and the block acts on its rising edge. When a strobe drops a ready that was high, that port's interrupt request is set. Each port drives a processor flag that is active while its ready is low, and only while the group is selected. The interrupt requests of both ports merge onto one interrupt line when the enable option is set, whatever the group latch holds.

Top module: `gsel_pport`

## Requirements
- R1: After reset the group latch holds 0, both ports are inputs (`pa_oe`/`pb_oe` low), both readies and both interrupt requests are clear, and `flag_a`, `flag_b` and `irq` are low.
- R2: A write to address 1 always loads the group latch. Only while it holds `GROUP_ID` (0x08) do other addresses respond. Otherwise reads return 0x00 and writes to addresses 2, 4 and 6 have no effect.
- R3: The register map applies while the group is selected:
  - write to 2 loads the direction register, with bit 0 for port A, bit 1 for port B, and 1 meaning output;
  - write to 4 loads port A data, and write to 6 loads port B data;
  - read of 2 returns status, read of 4 returns port A data, and read of 6 returns port B data;
  - reads of any other address return 0x00.
- R4: On an output port, a processor write to its data register drives the byte on the port pins and raises ready on the next clock edge.
- R5: On an input port, a processor read of its data register raises ready on the next clock edge. A processor write to an input port's data register has no effect.
- R6: A strobe rising before clock edge k is acted on at edge k+2. At that edge ready is cleared, and on an input port the pin byte is captured and becomes the port's read value.
- R7: A strobe that clears a high ready sets that port's interrupt request. A strobe while ready is already low sets none. Any processor read or write of the port's data register clears the port's request.
- R8: Status bits are as follows: bit 0 is A ready, bit 1 is B ready, bit 2 is A request, bit 3 is B request, and bits 7..4 read 0.
- R9: `flag_a` (`flag_b`) is high exactly when the group is selected and port A (B) ready is low.
- R10: `irq` is high when `irq_en` is set and either port has a request, regardless of the group latch.
- R11: A direction-register write that changes a port's direction clears that port's ready and request. Rewriting the same direction leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 3 | I/O port address |
| io_wr | input | 1 | Processor output (write) strobe |
| io_rd | input | 1 | Processor input (read) strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while address is held |
| irq_en | input | 1 | Interrupt merge enable option |
| flag_a | output | 1 | Processor flag for port A (ready low) |
| flag_b | output | 1 | Processor flag for port B (ready low) |
| irq | output | 1 | Merged interrupt request |
| pa_dout | output | 8 | Port A output byte |
| pa_oe | output | 1 | Port A driven as output |
| pa_din | input | 8 | Port A input byte |
| pa_stb | input | 1 | Port A peripheral strobe |
| pa_rdy | output | 1 | Port A ready |
| pb_dout | output | 8 | Port B output byte |
| pb_oe | output | 1 | Port B driven as output |
| pb_din | input | 8 | Port B input byte |
| pb_stb | input | 1 | Port B peripheral strobe |
| pb_rdy | output | 1 | Port B ready |

## Verification
The bench builds the block with its defaults: 8-bit data, group number 0x08 and a two-stage strobe synchronizer. The group value makes selection and deselection testable with ordinary byte writes. The two-stage depth places the strobe's effect exactly at the third edge, so the test can probe readiness one edge before and at the action edge. With both ports present, one port can be output while the other is input, and the status, flag and merged-interrupt paths are checked for each.

// File: rtl/gsel_pkg.sv
package gsel_pkg;
    localparam int ADDR_W = 3;
    localparam int NPORTS = 2;

    localparam logic [ADDR_W-1:0] ADR_GROUP = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_DATA0 = 3'd4;

    // per-access decode produced from the bus and the group latch
    typedef struct packed {
        logic              grp_sel;
        logic              ctrl_wr;
        logic              stat_sel;
        logic [NPORTS-1:0] data_sel;
        logic [NPORTS-1:0] data_wr;
        logic [NPORTS-1:0] data_rd;
    } bus_dec_t;

    // data registers sit at even addresses starting at ADR_DATA0
    function automatic logic [ADDR_W-1:0] port_addr(input int idx);
        return ADR_DATA0 + ADDR_W'(2 * idx);
    endfunction

    // ready bits low, request bits above them
    function automatic logic [2*NPORTS-1:0] pack_status(
        input logic [NPORTS-1:0] rdy,
        input logic [NPORTS-1:0] pend
    );
        return {pend, rdy};
    endfunction
endpackage

// File: rtl/gsel_decode.sv
module gsel_decode
    import gsel_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int GROUP_ID = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output bus_dec_t          dec
);
    logic [DATA_W-1:0] grp_q;
    logic              sel;

    always_ff @(posedge clk) begin
        if (rst)
            grp_q <= '0;
        else if (io_wr && io_addr == ADR_GROUP)
            grp_q <= io_wdata;
    end

    assign sel = (grp_q == DATA_W'(GROUP_ID));

    always_comb begin
        dec          = '0;
        dec.grp_sel  = sel;
        dec.ctrl_wr  = sel && io_wr && (io_addr == ADR_CTRL);
        dec.stat_sel = sel && (io_addr == ADR_CTRL);
        for (int i = 0; i < NPORTS; i++) begin
            dec.data_sel[i] = sel && (io_addr == port_addr(i));
            dec.data_wr[i]  = dec.data_sel[i] && io_wr;
            dec.data_rd[i]  = dec.data_sel[i] && io_rd;
        end
    end
endmodule

// File: rtl/gsel_stb_sync.sv
module gsel_stb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stb_raw,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            last_q <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], stb_raw};
            last_q <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] && !last_q;
endmodule

// File: rtl/gsel_port_ch.sv
module gsel_port_ch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_out,
    input  logic              dir_chg,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pin_in,
    input  logic              stb_rise,
    output logic              rdy,
    output logic              pend,
    output logic [DATA_W-1:0] out_q,
    output logic [DATA_W-1:0] in_q
);
    logic arm;

    // the access that raises ready depends on direction
    assign arm = dir_out ? cpu_wr : cpu_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy   <= 1'b0;
            pend  <= 1'b0;
            out_q <= '0;
            in_q  <= '0;
        end else begin
            if (dir_chg) begin
                rdy  <= 1'b0;
                pend <= 1'b0;
            end else begin
                if (stb_rise)
                    rdy <= 1'b0;
                else if (arm)
                    rdy <= 1'b1;

                if (stb_rise && rdy)
                    pend <= 1'b1;
                else if (cpu_wr || cpu_rd)
                    pend <= 1'b0;
            end
            if (dir_out && cpu_wr)
                out_q <= wdata;
            if (!dir_out && stb_rise)
                in_q <= pin_in;
        end
    end
endmodule

// File: rtl/gsel_pport.sv
module gsel_pport
    import gsel_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int GROUP_ID    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              irq_en,
    output logic              flag_a,
    output logic              flag_b,
    output logic              irq,
    output logic [DATA_W-1:0] pa_dout,
    output logic              pa_oe,
    input  logic [DATA_W-1:0] pa_din,
    input  logic              pa_stb,
    output logic              pa_rdy,
    output logic [DATA_W-1:0] pb_dout,
    output logic              pb_oe,
    input  logic [DATA_W-1:0] pb_din,
    input  logic              pb_stb,
    output logic              pb_rdy
);
    localparam int STAT_W = 2 * NPORTS;

    bus_dec_t          dec;
    logic              grp_sel;
    logic              ctrl_wr;
    logic [NPORTS-1:0] dir_q;
    logic [NPORTS-1:0] dir_chg;
    logic [NPORTS-1:0] stb_raw;
    logic [NPORTS-1:0] stb_evt;
    logic [NPORTS-1:0] rdy;
    logic [NPORTS-1:0] pend;
    logic [DATA_W-1:0] din   [NPORTS];
    logic [DATA_W-1:0] out_q [NPORTS];
    logic [DATA_W-1:0] in_q  [NPORTS];

    gsel_decode #(.DATA_W(DATA_W), .GROUP_ID(GROUP_ID)) u_dec (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .dec(dec)
    );

    assign grp_sel = dec.grp_sel;
    assign ctrl_wr = dec.ctrl_wr;

    always_ff @(posedge clk) begin
        if (rst)
            dir_q <= '0;
        else if (ctrl_wr)
            dir_q <= io_wdata[NPORTS-1:0];
    end

    assign dir_chg = ctrl_wr ? (io_wdata[NPORTS-1:0] ^ dir_q) : '0;
    assign stb_raw = {pb_stb, pa_stb};
    assign din[0]  = pa_din;
    assign din[1]  = pb_din;

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        gsel_stb_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst(rst), .stb_raw(stb_raw[i]), .rise(stb_evt[i])
        );
        gsel_port_ch #(.DATA_W(DATA_W)) u_ch (
            .clk(clk), .rst(rst), .dir_out(dir_q[i]), .dir_chg(dir_chg[i]),
            .cpu_wr(dec.data_wr[i]), .cpu_rd(dec.data_rd[i]),
            .wdata(io_wdata), .pin_in(din[i]), .stb_rise(stb_evt[i]),
            .rdy(rdy[i]), .pend(pend[i]), .out_q(out_q[i]), .in_q(in_q[i])
        );
    end

    always_comb begin
        io_rdata = '0;
        if (dec.stat_sel)
            io_rdata = DATA_W'(pack_status(rdy, pend));
        for (int i = 0; i < NPORTS; i++)
            if (dec.data_sel[i])
                io_rdata = dir_q[i] ? out_q[i] : in_q[i];
    end

    assign flag_a  = grp_sel && !rdy[0];
    assign flag_b  = grp_sel && !rdy[1];
    assign irq     = irq_en && (|pend);
    assign pa_dout = out_q[0];
    assign pb_dout = out_q[1];
    assign pa_oe   = dir_q[0];
    assign pb_oe   = dir_q[1];
    assign pa_rdy  = rdy[0];
    assign pb_rdy  = rdy[1];

    logic [STAT_W-1:0] stat_dbg;
    assign stat_dbg = pack_status(rdy, pend);
    logic unused_ok;
    assign unused_ok = ^stat_dbg;
endmodule

// File: rtl/gsel_pport_chk.sv
module gsel_pport_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              io_wr,
    input logic              io_rd,
    input logic [DATA_W-1:0] io_rdata,
    input logic              irq_en,
    input logic              irq,
    input logic              flag_a,
    input logic              flag_b,
    input logic              pa_rdy,
    input logic              pb_rdy,
    input logic              pa_oe,
    input logic              grp_sel,
    input logic              ctrl_wr,
    input logic [1:0]        stb_evt
);
    p_unselected_read_r2: assert property (@(posedge clk) disable iff (rst)
        !grp_sel |-> io_rdata == '0);

    p_rdy_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pa_rdy) |-> $past(io_wr || io_rd));

    p_rdy_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(pa_rdy) |-> $past(stb_evt[0] || ctrl_wr));

    p_flag_a_r9: assert property (@(posedge clk) disable iff (rst)
        pa_rdy |-> !flag_a);

    p_flag_b_r9: assert property (@(posedge clk) disable iff (rst)
        pb_rdy |-> !flag_b);

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    p_dir_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(pa_oe) |-> $past(ctrl_wr));
endmodule

bind gsel_pport gsel_pport_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .irq_en(irq_en), .irq(irq), .flag_a(flag_a), .flag_b(flag_b),
    .pa_rdy(pa_rdy), .pb_rdy(pb_rdy), .pa_oe(pa_oe), .grp_sel(grp_sel),
    .ctrl_wr(ctrl_wr), .stb_evt(stb_evt)
);

// File: tb/gsel_pport_test.sv
module gsel_pport_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] io_addr = '0;
    logic       io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_wdata = '0, io_rdata;
    logic       irq_en = 1'b0, flag_a, flag_b, irq;
    logic [7:0] pa_dout, pb_dout, pa_din = '0, pb_din = '0;
    logic       pa_oe, pb_oe, pa_stb = 1'b0, pb_stb = 1'b0, pa_rdy, pb_rdy;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gsel_pport uut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic strobe(input bit port_b);
        @(negedge clk);
        if (port_b) pb_stb = 1'b1; else pa_stb = 1'b1;
        @(negedge clk);
        pa_stb = 1'b0; pb_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // {req[23:20], write[19], addr[18:16], wdata[15:8], expected read[7:0]}
    localparam int NV = 15;
    localparam logic [23:0] VEC [NV] = '{
        {4'd2, 1'b1, 3'd1, 8'h08, 8'h00},  // R2 select group
        {4'd8, 1'b0, 3'd2, 8'h00, 8'h00},  // R8 status idle
        {4'd3, 1'b1, 3'd2, 8'h01, 8'h00},  // R3 A output, B input
        {4'd4, 1'b1, 3'd4, 8'h5A, 8'h00},  // R4 load A
        {4'd4, 1'b0, 3'd2, 8'h00, 8'h01},  // R4 A ready
        {4'd3, 1'b0, 3'd4, 8'h00, 8'h5A},  // R3 read A
        {4'd5, 1'b1, 3'd6, 8'h33, 8'h00},  // R5 write to input B
        {4'd5, 1'b0, 3'd2, 8'h00, 8'h01},  // R5 no B ready from write
        {4'd5, 1'b0, 3'd6, 8'h00, 8'h00},  // R5 dummy read B
        {4'd8, 1'b0, 3'd2, 8'h00, 8'h03},  // R8 both ready
        {4'd2, 1'b1, 3'd1, 8'h07, 8'h00},  // R2 deselect
        {4'd2, 1'b0, 3'd2, 8'h00, 8'h00},  // R2 status hidden
        {4'd2, 1'b0, 3'd4, 8'h00, 8'h00},  // R2 data hidden
        {4'd2, 1'b1, 3'd1, 8'h08, 8'h00},  // R2 reselect
        {4'd2, 1'b0, 3'd2, 8'h00, 8'h03}   // R2 state kept
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pa_oe", {7'd0, pa_oe}, 8'h0);
        chk("R1 pb_oe", {7'd0, pb_oe}, 8'h0);
        chk("R1 rdy", {6'd0, pb_rdy, pa_rdy}, 8'h0);
        chk("R1 flags", {6'd0, flag_b, flag_a}, 8'h0);
        chk("R1 irq", {7'd0, irq}, 8'h0);
        rd(3'd2, v);
        chk("R1 unselected status", v, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
            else begin
                rd(VEC[i][18:16], v);
                chk($sformatf("R%0d vector %0d", VEC[i][23:20], i), v, VEC[i][7:0]);
            end
        end
        chk("R4 pins", pa_dout, 8'h5A);
        chk("R3 dir pins", {6'd0, pb_oe, pa_oe}, 8'h01);
        rd(3'd3, v);
        chk("R3 unmapped addr", v, 8'h00);
        chk("R9 flags while ready", {6'd0, flag_b, flag_a}, 8'h0);

        // R7 and R9: strobe on output port A clears ready, sets request
        strobe(1'b0);
        rd(3'd2, v);
        chk("R7 status after A strobe", v, 8'h06);
        chk("R9 flag_a low ready", {7'd0, flag_a}, 8'h1);
        chk("R10 irq disabled", {7'd0, irq}, 8'h0);
        irq_en = 1'b1;
        #1 chk("R10 irq enabled", {7'd0, irq}, 8'h1);
        wr(3'd1, 8'h00);
        #1 chk("R10 irq ignores group", {7'd0, irq}, 8'h1);
        chk("R9 flag gated by group", {7'd0, flag_a}, 8'h0);
        wr(3'd1, 8'h08);

        // R6 timing and capture on input port B
        pb_din = 8'hC3;
        @(negedge clk); pb_stb = 1'b1;
        @(negedge clk); pb_stb = 1'b0;
        @(negedge clk);
        chk("R6 ready held before action edge", {7'd0, pb_rdy}, 8'h1);
        @(negedge clk);
        chk("R6 ready cleared at action edge", {7'd0, pb_rdy}, 8'h0);
        rd(3'd2, v);
        chk("R8 both requests", v, 8'h0C);
        rd(3'd6, v);
        chk("R6 captured byte", v, 8'hC3);
        rd(3'd2, v);
        chk("R7 read clears B request", v, 8'h06);

        // R7 strobe while ready low sets no request
        rd(3'd4, v);
        rd(3'd2, v);
        chk("R7 A access clears request", v, 8'h02);
        strobe(1'b0);
        rd(3'd2, v);
        chk("R7 no request when ready low", v, 8'h02);
        chk("R10 irq idle", {7'd0, irq}, 8'h0);

        // R11 direction change clears B ready; same direction keeps it
        wr(3'd2, 8'h03);
        rd(3'd2, v);
        chk("R11 change clears ready", v, 8'h00);
        chk("R11 pb_oe", {7'd0, pb_oe}, 8'h1);
        wr(3'd6, 8'h9E);
        wr(3'd2, 8'h03);
        rd(3'd2, v);
        chk("R11 same direction keeps ready", v, 8'h02);
        chk("R4 B pins", pb_dout, 8'h9E);

        finish_run();
    end
endmodule